// File: doc/BRIEF.md
# Register-to-Unit Hazard Dependency Matrix

This block is the dependency grid of an out-of-order scoreboard. Each row stands for one function unit and each column for one architectural register. When an instruction is handed to a unit, the row records a pending-read flag for every source register and a pending-write flag for the destination register. Registers arrive as one-hot (or multi-hot, for sources) bit vectors, so a cell needs no tag comparison: it is simply a bit that is set or clear.

The grid exports two per-register vectors, the OR of every row's read flags and the OR of every row's write flags. Issue logic elsewhere uses them to hold back any later instruction that touches a busy register. Each row also reports ready when none of its flags is set. A row is wiped when its unit writes back its result or when the unit is released. Every flag is a reset-priority set/reset element built from a clocked flop: a clear in the same cycle as a set wins.

Top module: `hazard_matrix`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it rises, rd_pending_o and wr_pending_o are all zero and row_ready_o is all ones; an assertion of rst_ni mid-run clears every flag at once.
- R2: A rising clock edge with issue_en_i[f] high and no clear on row f sets row f's read flag for every register whose bit is 1 in row f's slice src_regs_i[f*NUM_REG +: NUM_REG]; those registers appear in rd_pending_o after that edge.
- R3: Under the same condition, row f's write flag is set for every register whose bit is 1 in dst_reg_i[f*NUM_REG +: NUM_REG]; those registers appear in wr_pending_o after that edge.
- R4: Flags only accumulate: with issue_en_i[f] low the row's src/dst slices are ignored, and a second issue to a row ORs new flags into the existing ones.
- R5: go_write_i[f] high at a clock edge clears all read and write flags of row f; row_ready_o[f] is high after that edge.
- R6: release_i[f] high at a clock edge clears all flags of row f in the same way.
- R7: If issue_en_i[f] and a clear (go_write_i[f] or release_i[f]) are high at the same edge, row f ends with no flags set.
- R8: row_ready_o[f] is high exactly when row f holds no read flag and no write flag.
- R9: bit r of rd_pending_o (wr_pending_o) is the OR of column r's read (write) flags over all rows, so clearing one row leaves hazards of other rows on the same register visible.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, flags update on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset, clears all flags |
| issue_en_i | input | NUM_FU | Per-row issue strobe |
| src_regs_i | input | NUM_FU*NUM_REG | Per-row source register mask, row f in bits f*NUM_REG +: NUM_REG |
| dst_reg_i | input | NUM_FU*NUM_REG | Per-row one-hot destination register, same layout |
| go_write_i | input | NUM_FU | Per-row writeback clear |
| release_i | input | NUM_FU | Per-row unit release clear |
| rd_pending_o | output | NUM_REG | Registers with any pending read |
| wr_pending_o | output | NUM_REG | Registers with any pending write |
| row_ready_o | output | NUM_FU | Row holds no flags |

## Verification
The bench builds the matrix with NUM_FU = 4 and NUM_REG = 8, small enough that directed steps can place overlapping hazards from several rows on the same register and then peel them away one row at a time. With only four rows, a sparse random phase regularly lands issue and clear on the same row in one cycle, which exercises the clear-wins rule far more often than the default sizes would. Mid-run reset and idle cycles with live-looking but disabled source/destination slices cover the ignore and hold cases.

// File: rtl/hm_pkg.sv
package hm_pkg;
  localparam int unsigned DEF_NUM_FU  = 16;
  localparam int unsigned DEF_NUM_REG = 30;
endpackage

// File: rtl/hm_srflop.sv
// Reset-priority set/reset element, modelled as a clocked flop.
module hm_srflop #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= (q_q | set_i) & ~clr_i;
  end

  assign q_o = q_q;

  assert_clear_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|clr_i) |=> ((q_o & $past(clr_i)) == '0));

  assert_set_takes_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((q_o & $past(set_i & ~clr_i)) == $past(set_i & ~clr_i)));

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((set_i == '0) && (clr_i == '0)) |=> $stable(q_o));
endmodule

// File: rtl/hm_row.sv
// One function-unit row: read and write flag vectors plus ready.
module hm_row #(
  parameter int unsigned NUM_REG = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               issue_en_i,
  input  logic [NUM_REG-1:0] src_i,
  input  logic [NUM_REG-1:0] dst_i,
  input  logic               go_write_i,
  input  logic               release_i,
  output logic [NUM_REG-1:0] rd_o,
  output logic [NUM_REG-1:0] wr_o,
  output logic               ready_o
);
  logic [NUM_REG-1:0] clr_v, set_rd, set_wr;

  assign clr_v  = {NUM_REG{go_write_i | release_i}};
  assign set_rd = {NUM_REG{issue_en_i}} & src_i;
  assign set_wr = {NUM_REG{issue_en_i}} & dst_i;

  hm_srflop #(.W(NUM_REG)) u_rd (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(set_rd), .clr_i(clr_v), .q_o(rd_o)
  );

  hm_srflop #(.W(NUM_REG)) u_wr (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(set_wr), .clr_i(clr_v), .q_o(wr_o)
  );

  assign ready_o = ~(|rd_o) & ~(|wr_o);
endmodule

// File: rtl/hm_colmerge.sv
// Column-wise OR of a row-major flag grid.
module hm_colmerge #(
  parameter int unsigned NUM_FU  = 4,
  parameter int unsigned NUM_REG = 8
) (
  input  logic [NUM_FU-1:0][NUM_REG-1:0] grid_i,
  output logic [NUM_REG-1:0]             col_o
);
  for (genvar r = 0; r < NUM_REG; r++) begin : g_col
    logic [NUM_FU-1:0] col_bits;
    for (genvar f = 0; f < NUM_FU; f++) begin : g_bit
      assign col_bits[f] = grid_i[f][r];
    end
    assign col_o[r] = |col_bits;
  end
endmodule

// File: rtl/hazard_matrix.sv
module hazard_matrix
  import hm_pkg::*;
#(
  parameter int unsigned NUM_FU  = DEF_NUM_FU,
  parameter int unsigned NUM_REG = DEF_NUM_REG
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_FU-1:0]         issue_en_i,
  input  logic [NUM_FU*NUM_REG-1:0] src_regs_i,
  input  logic [NUM_FU*NUM_REG-1:0] dst_reg_i,
  input  logic [NUM_FU-1:0]         go_write_i,
  input  logic [NUM_FU-1:0]         release_i,
  output logic [NUM_REG-1:0]        rd_pending_o,
  output logic [NUM_REG-1:0]        wr_pending_o,
  output logic [NUM_FU-1:0]         row_ready_o
);
  localparam int unsigned CELLS = NUM_FU * NUM_REG;

  logic [NUM_FU-1:0][NUM_REG-1:0] rd_grid, wr_grid;

  for (genvar f = 0; f < NUM_FU; f++) begin : g_row
    hm_row #(.NUM_REG(NUM_REG)) u_row (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .issue_en_i (issue_en_i[f]),
      .src_i      (src_regs_i[f*NUM_REG +: NUM_REG]),
      .dst_i      (dst_reg_i[f*NUM_REG +: NUM_REG]),
      .go_write_i (go_write_i[f]),
      .release_i  (release_i[f]),
      .rd_o       (rd_grid[f]),
      .wr_o       (wr_grid[f]),
      .ready_o    (row_ready_o[f])
    );

    assert_row_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (go_write_i[f] || release_i[f]) |=> row_ready_o[f]);

    assert_issue_visible_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (issue_en_i[f] && !go_write_i[f] && !release_i[f]) |=>
        (((rd_pending_o & $past(src_regs_i[f*NUM_REG +: NUM_REG]))
            == $past(src_regs_i[f*NUM_REG +: NUM_REG])) &&
         ((wr_pending_o & $past(dst_reg_i[f*NUM_REG +: NUM_REG]))
            == $past(dst_reg_i[f*NUM_REG +: NUM_REG]))));
  end

  hm_colmerge #(.NUM_FU(NUM_FU), .NUM_REG(NUM_REG)) u_rd_merge (
    .grid_i(rd_grid), .col_o(rd_pending_o)
  );

  hm_colmerge #(.NUM_FU(NUM_FU), .NUM_REG(NUM_REG)) u_wr_merge (
    .grid_i(wr_grid), .col_o(wr_pending_o)
  );

  assert_ready_vs_pending_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&row_ready_o) |-> ((rd_pending_o == '0) && (wr_pending_o == '0)));

  assert_pending_has_owner_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_pending_o != '0) || (wr_pending_o != '0)) |-> !(&row_ready_o));

  initial assert_cells_nonzero: assert (CELLS > 0);
endmodule

// File: tb/hazard_matrix_test.sv
`timescale 1ns/1ps
module hazard_matrix_test;
  localparam int NF = 4;
  localparam int NR = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [NF-1:0]    issue_en = '0, go_write = '0, rel = '0;
  logic [NF*NR-1:0] src = '0, dst = '0;
  logic [NR-1:0]    rd_p, wr_p;
  logic [NF-1:0]    rdy;

  always #2 clk = ~clk;

  hazard_matrix #(.NUM_FU(NF), .NUM_REG(NR)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .issue_en_i(issue_en), .src_regs_i(src),
    .dst_reg_i(dst), .go_write_i(go_write), .release_i(rel),
    .rd_pending_o(rd_p), .wr_pending_o(wr_p), .row_ready_o(rdy)
  );

  typedef struct {
    logic [NR-1:0] rd;
    logic [NR-1:0] wr;
    logic [NF-1:0] rdy;
    string         tag;
  } exp_t;

  exp_t exp_q[$];
  logic [NF-1:0][NR-1:0] m_rd = '0, m_wr = '0;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic compare(input exp_t e);
    n_chk++;
    if (rd_p !== e.rd || wr_p !== e.wr || rdy !== e.rdy) begin
      n_bad++;
      $display("FAIL %s: rd=%h wr=%h rdy=%h expected rd=%h wr=%h rdy=%h",
               e.tag, rd_p, wr_p, rdy, e.rd, e.wr, e.rdy);
    end
  endtask

  function automatic exp_t model_out(input string tag);
    exp_t e;
    e.rd = '0; e.wr = '0; e.tag = tag;
    for (int f = 0; f < NF; f++) begin
      e.rd |= m_rd[f];
      e.wr |= m_wr[f];
      e.rdy[f] = (m_rd[f] == '0) && (m_wr[f] == '0);
    end
    return e;
  endfunction

  function automatic logic [NF*NR-1:0] at(input int f, input logic [NR-1:0] v);
    logic [NF*NR-1:0] r;
    r = '0;
    r[f*NR +: NR] = v;
    return r;
  endfunction

  // Driver: applies one cycle of stimulus and queues the expected result.
  task automatic step(input logic [NF-1:0] iss, input logic [NF*NR-1:0] s,
                      input logic [NF*NR-1:0] d, input logic [NF-1:0] gw,
                      input logic [NF-1:0] rl, input string tag);
    @(negedge clk);
    issue_en = iss; src = s; dst = d; go_write = gw; rel = rl;
    for (int f = 0; f < NF; f++) begin
      if (gw[f] || rl[f]) begin
        m_rd[f] = '0; m_wr[f] = '0;
      end else if (iss[f]) begin
        m_rd[f] |= s[f*NR +: NR];
        m_wr[f] |= d[f*NR +: NR];
      end
    end
    exp_q.push_back(model_out(tag));
  endtask

  // Monitor: compares one queued item per clock, after the edge settles.
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) compare(exp_q.pop_front());
  end

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    exp_t e;
    #9;
    e = model_out("R1 in reset");
    compare(e);
    @(negedge clk); rst_ni = 1'b1;
    step('0, '0, '0, '0, '0, "R1 after reset");

    // Reads and writes recorded per row
    step(4'b0001, at(0, 8'b0000_1010), at(0, 8'b0000_0000), '0, '0, "R2 row0 src r1 r3");
    step(4'b0010, at(1, 8'b0000_0000), at(1, 8'b0010_0000), '0, '0, "R3 row1 dst r5");
    // Disabled issue ignored
    step(4'b0000, at(2, 8'b1111_0000), at(2, 8'b1000_0000), '0, '0, "R4 issue_en low ignored");
    step(4'b0000, '0, '0, '0, '0, "R4 hold");
    // Accumulate on row0
    step(4'b0001, at(0, 8'b0100_0000), at(0, 8'b0000_0001), '0, '0, "R4 accumulate row0");
    // Overlap on r3 from row2, ready vector
    step(4'b0100, at(2, 8'b0000_1000), at(2, 8'b0000_0100), '0, '0, "R8 row2 busy");
    step(4'b0000, '0, '0, 4'b0001, '0, "R9 clear row0, r3 still held by row2");
    step(4'b0000, '0, '0, 4'b0010, '0, "R5 go_write row1");
    step(4'b0000, '0, '0, '0, 4'b0100, "R6 release row2");
    // Clear wins over issue
    step(4'b1000, at(3, 8'b1111_1111), at(3, 8'b0000_0010), 4'b1000, '0, "R7 issue+go_write");
    step(4'b1000, at(3, 8'b0001_0001), at(3, 8'b0100_0000), '0, 4'b1000, "R7 issue+release");
    step(4'b1001, at(3, 8'b0001_0001) | at(0, 8'b0000_0110),
         at(3, 8'b0100_0000) | at(0, 8'b1000_0000), 4'b1000, '0,
         "R7 row3 cleared, row0 issued same cycle");
    step(4'b0000, '0, '0, '0, '0, "R4 hold");

    // Mid-run reset
    @(negedge clk);
    issue_en = '0; go_write = '0; rel = '0; src = '0; dst = '0;
    rst_ni = 1'b0;
    m_rd = '0; m_wr = '0;
    #1;
    compare(model_out("R1 mid-run reset"));
    @(negedge clk); rst_ni = 1'b1;
    step('0, '0, '0, '0, '0, "R1 after mid-run reset");

    // Sparse random traffic
    for (int i = 0; i < 400; i++) begin
      logic [NF-1:0]    ri, rg, rr;
      logic [NF*NR-1:0] rs, rd;
      ri = NF'($urandom);
      rg = NF'($urandom & $urandom & $urandom);
      rr = NF'($urandom & $urandom & $urandom);
      rs = '0; rd = '0;
      for (int f = 0; f < NF; f++) begin
        rs[f*NR +: NR] = NR'($urandom & $urandom);
        rd[f*NR +: NR] = NR'(1) << ($urandom % NR);
      end
      step(ri, rs, rd, rg, rr, "R8 random traffic");
    end
    step('0, '0, '0, {NF{1'b1}}, '0, "R5 drain all rows");
    step('0, '0, '0, '0, '0, "R8 all ready");

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule